// File: doc/BRIEF.md
# Commit Head Retire Controller

This block decides, once per clock, which reorder-buffer head instructions leave the machine. Each hardware thread shows a small window of its oldest entries: the head and the entries directly behind it. For each entry the window gives a valid bit, a ready bit, whether it was squashed, whether it has executed, whether it faulted, whether it must run serialised (a non-speculative op, a barrier or a store-conditional), whether it is a load, a store, or a nop/instruction prefetch, and its sequence number. A per-thread flag reports stores still waiting for writeback. The block walks commit slots in order. Each slot takes the oldest remaining entry of the first eligible thread, searching from a rotating start thread. It puts out retire strobes, a clear-can-commit strobe, a request to execute a serialised head, a request to replay an uncached load, a trap request, a per-thread committed-store flag, the youngest committed sequence number per thread, and the architectural PC, next-PC and micro-PC of each thread.

Each thread has a two-state machine. In `TH_RUN` its heads may retire. The transition `TH_RUN -> TH_TRAP_WAIT` is taken when the thread's faulting head raises a trap. In `TH_TRAP_WAIT` the thread cannot be selected. The transition `TH_TRAP_WAIT -> TH_RUN` is taken when `trap_done` for that thread is high. A rotating start pointer moves to the next thread on every clock.

Top module: `cmt_retire_ctrl`

## Requirements
- R1: At most COMMIT_WIDTH non-squashed instructions commit per cycle (`commit_cnt`). The walk stops as soon as that many have committed.
- R2: Threads are searched in order starting from a start thread that is 0 after reset and advances by one, modulo the thread count, every clock. The first thread in `TH_RUN` with a valid unconsumed entry is selected. The walk stops when no thread qualifies or when the selected entry is not ready.
- R3: A ready squashed entry is removed at once: its `retire_mask` bit is set. It does not count toward `commit_cnt`, and the walk goes on. `retire_mask` bit t*COMMIT_WIDTH+k stands for thread t, window entry k.
- R4: A ready, unexecuted entry marked serialised stops the walk. If nothing has committed earlier in the cycle and its thread has no pending writeback, the block asserts `serial_req` and sets the entry's `hold_mask` bit. `req_tid` and `req_seq` then carry its thread and sequence number. Otherwise nothing is requested.
- R5: A ready, unexecuted load that is not serialised follows the same rule as R4, but raises `uload_req` instead.
- R6: A ready, executed, faulting entry stops the walk and is not retired. If it is first in the cycle and its thread has no pending writeback, the block raises `trap_req` with `req_tid`/`req_seq` and the thread enters `TH_TRAP_WAIT`. There it retires nothing until `trap_done` returns it to `TH_RUN`.
- R7: For each commit, PC takes next-PC, next-PC takes next-next-PC, next-next-PC grows by INST_BYTES, micro-PC takes next-micro-PC and next-micro-PC becomes the new micro-PC plus one. After reset, PC = RESET_PC, next-PC = RESET_PC+INST_BYTES, next-next-PC = RESET_PC+2*INST_BYTES, micro-PC = 0 and next-micro-PC = 1.
- R8: `store_commit[t]` is high only in a cycle in which a store of thread t commits.
- R9: `inst_cnt` counts the commits of the cycle that are not marked nop/prefetch.
- R10: A ready, unexecuted entry that is neither serialised nor a load raises `unk_err` and stops the walk.
- R11: `done_vld[t]` is high when thread t committed this cycle. `done_seq` slice t then holds the sequence number of its last committed entry, and is zero otherwise.
- R12: While reset is held, both threads are in `TH_RUN`, no strobe or request is active and the PCs hold their reset values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hd_valid | input | NUM_THREADS*COMMIT_WIDTH | Window entry present |
| hd_ready | input | NUM_THREADS*COMMIT_WIDTH | Entry may be considered for commit |
| hd_squashed | input | NUM_THREADS*COMMIT_WIDTH | Entry was squashed |
| hd_executed | input | NUM_THREADS*COMMIT_WIDTH | Entry has executed |
| hd_fault | input | NUM_THREADS*COMMIT_WIDTH | Entry carries a fault |
| hd_serial | input | NUM_THREADS*COMMIT_WIDTH | Non-speculative, barrier or store-conditional |
| hd_load | input | NUM_THREADS*COMMIT_WIDTH | Entry is a load |
| hd_store | input | NUM_THREADS*COMMIT_WIDTH | Entry is a store |
| hd_nop | input | NUM_THREADS*COMMIT_WIDTH | Nop or instruction prefetch |
| hd_seq | input | NUM_THREADS*COMMIT_WIDTH*SEQ_W | Sequence numbers |
| wb_pending | input | NUM_THREADS | Stores awaiting writeback, per thread |
| trap_done | input | NUM_THREADS | Trap handled, thread may resume |
| retire_mask | output | NUM_THREADS*COMMIT_WIDTH | Entries removed this cycle |
| hold_mask | output | NUM_THREADS*COMMIT_WIDTH | Entry whose can-commit bit is cleared |
| commit_cnt | output | CNT_W | Non-squashed commits this cycle |
| inst_cnt | output | CNT_W | Commits excluding nops/prefetches |
| done_vld | output | NUM_THREADS | Thread committed this cycle |
| done_seq | output | NUM_THREADS*SEQ_W | Youngest committed sequence number per thread |
| store_commit | output | NUM_THREADS | A store committed this cycle |
| serial_req | output | 1 | Execute the serialised head |
| uload_req | output | 1 | Replay the uncached load head |
| trap_req | output | 1 | Take a trap for the faulting head |
| unk_err | output | 1 | Unexecuted head of unknown kind |
| req_tid | output | TID_W | Thread of the request |
| req_seq | output | SEQ_W | Sequence number of the request |
| trap_wait | output | NUM_THREADS | Thread is in TH_TRAP_WAIT |
| pc_out | output | NUM_THREADS*PC_W | Architectural PC per thread |
| npc_out | output | NUM_THREADS*PC_W | Next PC per thread |
| upc_out | output | NUM_THREADS*UPC_W | Micro-PC per thread |

## Verification
The interesting collisions come when a commit and a special head fall in the same cycle. Squashed removals on one thread can run alongside full-width commits on another, and a committed store can sit directly in front of a serialised, load or faulting head that must then be held back. Directed cycles build these windows: a thread of all-squashed entries in front of a thread of ready ones, and a commit followed by a serialised head, with and without pending writeback. Random windows with wide odds on each attribute then mix them freely. On every cycle a behavioural model in the bench walks the same windows and predicts the masks, counts, requests, per-thread state and PCs, and the design's outputs are judged against that prediction.

// File: rtl/cmt_pkg.sv
package cmt_pkg;

    typedef enum logic {
        TH_RUN       = 1'b0,
        TH_TRAP_WAIT = 1'b1
    } th_state_e;

endpackage

// File: rtl/cmt_select.sv
module cmt_select #(
    parameter int T     = 2,
    parameter int W     = 4,
    parameter int SEQ_W = 16,
    parameter int CNT_W = 3,
    parameter int TID_W = 1
) (
    input  logic [T*W-1:0]       hv,
    input  logic [T*W-1:0]       hrdy,
    input  logic [T*W-1:0]       hsq,
    input  logic [T*W-1:0]       hex,
    input  logic [T*W-1:0]       hflt,
    input  logic [T*W-1:0]       hser,
    input  logic [T*W-1:0]       hld,
    input  logic [T*W-1:0]       hst,
    input  logic [T*W-1:0]       hnop,
    input  logic [T*W*SEQ_W-1:0] hseq,
    input  logic [T-1:0]         run_ok,
    input  logic [T-1:0]         st_pend,
    input  logic [TID_W-1:0]     start_tid,
    output logic [T*W-1:0]       retire_mask,
    output logic [T*W-1:0]       hold_mask,
    output logic [CNT_W-1:0]     commit_cnt,
    output logic [CNT_W-1:0]     inst_cnt,
    output logic [T*CNT_W-1:0]   adv_cnt,
    output logic [T-1:0]         done_vld,
    output logic [T*SEQ_W-1:0]   done_seq,
    output logic [T-1:0]         store_commit,
    output logic                 serial_req,
    output logic                 uload_req,
    output logic                 trap_req,
    output logic                 unk_err,
    output logic [TID_W-1:0]     req_tid,
    output logic [SEQ_W-1:0]     req_seq
);

    int   cons  [T];
    int   advn  [T];
    int   committed;
    int   counted;
    int   sel;
    int   cand;
    int   e;
    logic stop;

    always_comb begin
        retire_mask  = '0;
        hold_mask    = '0;
        done_vld     = '0;
        done_seq     = '0;
        store_commit = '0;
        serial_req   = 1'b0;
        uload_req    = 1'b0;
        trap_req     = 1'b0;
        unk_err      = 1'b0;
        req_tid      = '0;
        req_seq      = '0;
        committed    = 0;
        counted      = 0;
        sel          = 0;
        cand         = 0;
        e            = 0;
        stop         = 1'b0;
        for (int t = 0; t < T; t++) begin
            cons[t] = 0;
            advn[t] = 0;
        end
        for (int s = 0; s < T*W; s++) begin
            if (!stop && committed < W) begin
                sel = -1;
                for (int k = 0; k < T; k++) begin
                    cand = (int'(start_tid) + k) % T;
                    if (sel < 0 && run_ok[cand] && cons[cand] < W &&
                        hv[cand*W + cons[cand]])
                        sel = cand;
                end
                if (sel < 0) begin
                    stop = 1'b1;
                end else begin
                    e = sel*W + cons[sel];
                    if (!hrdy[e]) begin
                        stop = 1'b1;
                    end else if (hsq[e]) begin
                        retire_mask[e] = 1'b1;
                        cons[sel]      = cons[sel] + 1;
                    end else if (!hex[e]) begin
                        stop = 1'b1;
                        if (hser[e] || hld[e]) begin
                            if (committed == 0 && !st_pend[sel]) begin
                                hold_mask[e] = 1'b1;
                                req_tid      = TID_W'(sel);
                                req_seq      = hseq[e*SEQ_W +: SEQ_W];
                                if (hser[e]) serial_req = 1'b1;
                                else         uload_req  = 1'b1;
                            end
                        end else begin
                            unk_err = 1'b1;
                        end
                    end else if (hflt[e]) begin
                        stop = 1'b1;
                        if (committed == 0 && !st_pend[sel]) begin
                            trap_req = 1'b1;
                            req_tid  = TID_W'(sel);
                            req_seq  = hseq[e*SEQ_W +: SEQ_W];
                        end
                    end else begin
                        retire_mask[e]                 = 1'b1;
                        cons[sel]                      = cons[sel] + 1;
                        advn[sel]                      = advn[sel] + 1;
                        committed                      = committed + 1;
                        done_vld[sel]                  = 1'b1;
                        done_seq[sel*SEQ_W +: SEQ_W]   = hseq[e*SEQ_W +: SEQ_W];
                        if (hst[e])  store_commit[sel] = 1'b1;
                        if (!hnop[e]) counted          = counted + 1;
                    end
                end
            end
        end
        commit_cnt = CNT_W'(committed);
        inst_cnt   = CNT_W'(counted);
        for (int t = 0; t < T; t++)
            adv_cnt[t*CNT_W +: CNT_W] = CNT_W'(advn[t]);
    end

endmodule

// File: rtl/cmt_pc_track.sv
module cmt_pc_track #(
    parameter int               PC_W       = 32,
    parameter int               UPC_W      = 8,
    parameter int               CNT_W      = 3,
    parameter int               W          = 4,
    parameter int               INST_BYTES = 4,
    parameter logic [PC_W-1:0]  RESET_PC   = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] adv,
    output logic [PC_W-1:0]  pc,
    output logic [PC_W-1:0]  npc,
    output logic [UPC_W-1:0] upc
);

    localparam logic [PC_W-1:0] STEP = PC_W'(INST_BYTES);

    logic [PC_W-1:0]  pc_q, npc_q, nnpc_q;
    logic [UPC_W-1:0] upc_q, nupc_q;
    logic [PC_W-1:0]  p_d, n_d, nn_d;
    logic [UPC_W-1:0] u_d, nu_d;

    always_comb begin
        p_d  = pc_q;
        n_d  = npc_q;
        nn_d = nnpc_q;
        u_d  = upc_q;
        nu_d = nupc_q;
        for (int i = 0; i < W; i++) begin
            if (i < int'(adv)) begin
                p_d  = n_d;
                n_d  = nn_d;
                nn_d = nn_d + STEP;
                u_d  = nu_d;
                nu_d = u_d + UPC_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q   <= RESET_PC;
            npc_q  <= RESET_PC + STEP;
            nnpc_q <= RESET_PC + STEP + STEP;
            upc_q  <= '0;
            nupc_q <= UPC_W'(1);
        end else begin
            pc_q   <= p_d;
            npc_q  <= n_d;
            nnpc_q <= nn_d;
            upc_q  <= u_d;
            nupc_q <= nu_d;
        end
    end

    assign pc  = pc_q;
    assign npc = npc_q;
    assign upc = upc_q;

endmodule

// File: rtl/cmt_retire_ctrl.sv
module cmt_retire_ctrl
    import cmt_pkg::*;
#(
    parameter int              NUM_THREADS  = 2,
    parameter int              COMMIT_WIDTH = 4,
    parameter int              SEQ_W        = 16,
    parameter int              PC_W         = 32,
    parameter int              UPC_W        = 8,
    parameter int              INST_BYTES   = 4,
    parameter logic [PC_W-1:0] RESET_PC     = 32'h0000_1000,
    localparam int             NE           = NUM_THREADS * COMMIT_WIDTH,
    localparam int             CNT_W        = $clog2(COMMIT_WIDTH + 1),
    localparam int             TID_W        = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NE-1:0]                hd_valid,
    input  logic [NE-1:0]                hd_ready,
    input  logic [NE-1:0]                hd_squashed,
    input  logic [NE-1:0]                hd_executed,
    input  logic [NE-1:0]                hd_fault,
    input  logic [NE-1:0]                hd_serial,
    input  logic [NE-1:0]                hd_load,
    input  logic [NE-1:0]                hd_store,
    input  logic [NE-1:0]                hd_nop,
    input  logic [NE*SEQ_W-1:0]          hd_seq,
    input  logic [NUM_THREADS-1:0]       wb_pending,
    input  logic [NUM_THREADS-1:0]       trap_done,
    output logic [NE-1:0]                retire_mask,
    output logic [NE-1:0]                hold_mask,
    output logic [CNT_W-1:0]             commit_cnt,
    output logic [CNT_W-1:0]             inst_cnt,
    output logic [NUM_THREADS-1:0]       done_vld,
    output logic [NUM_THREADS*SEQ_W-1:0] done_seq,
    output logic [NUM_THREADS-1:0]       store_commit,
    output logic                         serial_req,
    output logic                         uload_req,
    output logic                         trap_req,
    output logic                         unk_err,
    output logic [TID_W-1:0]             req_tid,
    output logic [SEQ_W-1:0]             req_seq,
    output logic [NUM_THREADS-1:0]       trap_wait,
    output logic [NUM_THREADS*PC_W-1:0]  pc_out,
    output logic [NUM_THREADS*PC_W-1:0]  npc_out,
    output logic [NUM_THREADS*UPC_W-1:0] upc_out
);

    th_state_e                th_q [NUM_THREADS];
    th_state_e                th_d [NUM_THREADS];
    logic [TID_W-1:0]         start_q;
    logic [NUM_THREADS-1:0]   run_ok;
    logic [NUM_THREADS*CNT_W-1:0] adv_cnt;

    // thread state register and start pointer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int t = 0; t < NUM_THREADS; t++) th_q[t] <= TH_RUN;
            start_q <= '0;
        end else begin
            for (int t = 0; t < NUM_THREADS; t++) th_q[t] <= th_d[t];
            start_q <= (start_q == TID_W'(NUM_THREADS - 1)) ? '0 : start_q + TID_W'(1);
        end
    end

    // transitions
    always_comb begin
        for (int t = 0; t < NUM_THREADS; t++) begin
            th_d[t] = th_q[t];
            unique case (th_q[t])
                TH_RUN:       if (trap_req && req_tid == TID_W'(t)) th_d[t] = TH_TRAP_WAIT;
                TH_TRAP_WAIT: if (trap_done[t])                     th_d[t] = TH_RUN;
            endcase
        end
    end

    // state-decoded outputs
    always_comb begin
        for (int t = 0; t < NUM_THREADS; t++) begin
            run_ok[t]    = (th_q[t] == TH_RUN);
            trap_wait[t] = (th_q[t] == TH_TRAP_WAIT);
        end
    end

    cmt_select #(
        .T(NUM_THREADS), .W(COMMIT_WIDTH), .SEQ_W(SEQ_W), .CNT_W(CNT_W), .TID_W(TID_W)
    ) u_sel (
        .hv(hd_valid), .hrdy(hd_ready), .hsq(hd_squashed), .hex(hd_executed),
        .hflt(hd_fault), .hser(hd_serial), .hld(hd_load), .hst(hd_store),
        .hnop(hd_nop), .hseq(hd_seq), .run_ok(run_ok), .st_pend(wb_pending),
        .start_tid(start_q), .retire_mask(retire_mask), .hold_mask(hold_mask),
        .commit_cnt(commit_cnt), .inst_cnt(inst_cnt), .adv_cnt(adv_cnt),
        .done_vld(done_vld), .done_seq(done_seq), .store_commit(store_commit),
        .serial_req(serial_req), .uload_req(uload_req), .trap_req(trap_req),
        .unk_err(unk_err), .req_tid(req_tid), .req_seq(req_seq)
    );

    for (genvar t = 0; t < NUM_THREADS; t++) begin : g_pc
        cmt_pc_track #(
            .PC_W(PC_W), .UPC_W(UPC_W), .CNT_W(CNT_W), .W(COMMIT_WIDTH),
            .INST_BYTES(INST_BYTES), .RESET_PC(RESET_PC)
        ) u_pc (
            .clk(clk), .rst_n(rst_n),
            .adv(adv_cnt[t*CNT_W +: CNT_W]),
            .pc(pc_out[t*PC_W +: PC_W]),
            .npc(npc_out[t*PC_W +: PC_W]),
            .upc(upc_out[t*UPC_W +: UPC_W])
        );
    end

endmodule

// File: rtl/cmt_retire_chk.sv
module cmt_retire_chk #(
    parameter int NUM_THREADS  = 2,
    parameter int COMMIT_WIDTH = 4,
    parameter int SEQ_W        = 16,
    parameter int PC_W         = 32,
    localparam int NE          = NUM_THREADS * COMMIT_WIDTH,
    localparam int CNT_W       = $clog2(COMMIT_WIDTH + 1),
    localparam int TID_W       = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic [NUM_THREADS-1:0]      wb_pending,
    input logic [NE-1:0]               retire_mask,
    input logic [CNT_W-1:0]            commit_cnt,
    input logic [CNT_W-1:0]            inst_cnt,
    input logic [NUM_THREADS-1:0]      done_vld,
    input logic [NUM_THREADS-1:0]      store_commit,
    input logic                        serial_req,
    input logic                        uload_req,
    input logic                        trap_req,
    input logic                        unk_err,
    input logic [TID_W-1:0]            req_tid,
    input logic [NUM_THREADS-1:0]      trap_wait,
    input logic [NUM_THREADS*PC_W-1:0] pc_out
);

    assert_width_R1: assert property (@(posedge clk) disable iff (!rst_n)
        commit_cnt <= CNT_W'(COMMIT_WIDTH));

    assert_squash_extra_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(retire_mask) >= int'(commit_cnt));

    assert_one_stop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({serial_req, uload_req, trap_req, unk_err}));

    assert_req_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (serial_req || uload_req) |-> (commit_cnt == '0 && !wb_pending[req_tid]));

    assert_trap_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |-> (commit_cnt == '0 && !wb_pending[req_tid]));

    assert_trap_enter_R6: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |=> trap_wait[$past(req_tid)]);

    assert_nop_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
        inst_cnt <= commit_cnt);

    for (genvar t = 0; t < NUM_THREADS; t++) begin : g_th
        assert_wait_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
            trap_wait[t] |-> (retire_mask[t*COMMIT_WIDTH +: COMMIT_WIDTH] == '0));

        assert_pc_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
            trap_wait[t] |=> $stable(pc_out[t*PC_W +: PC_W]));

        assert_store_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
            store_commit[t] |-> done_vld[t]);
    end

endmodule

bind cmt_retire_ctrl cmt_retire_chk #(
    .NUM_THREADS(NUM_THREADS), .COMMIT_WIDTH(COMMIT_WIDTH), .SEQ_W(SEQ_W), .PC_W(PC_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .wb_pending(wb_pending), .retire_mask(retire_mask),
    .commit_cnt(commit_cnt), .inst_cnt(inst_cnt), .done_vld(done_vld),
    .store_commit(store_commit), .serial_req(serial_req), .uload_req(uload_req),
    .trap_req(trap_req), .unk_err(unk_err), .req_tid(req_tid),
    .trap_wait(trap_wait), .pc_out(pc_out)
);

// File: tb/cmt_retire_ctrl_test.sv
`timescale 1ns/100ps
module cmt_retire_ctrl_test;

    localparam int T  = 2;
    localparam int W  = 4;
    localparam int NE = T * W;
    localparam int SW = 16;
    localparam int PW = 32;
    localparam int UW = 8;
    localparam int CW = 3;
    localparam logic [PW-1:0] RPC = 32'h0000_1000;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst_n;
    logic [NE-1:0] hd_valid, hd_ready, hd_squashed, hd_executed, hd_fault;
    logic [NE-1:0] hd_serial, hd_load, hd_store, hd_nop;
    logic [NE*SW-1:0] hd_seq;
    logic [T-1:0] wb_pending, trap_done;
    logic [NE-1:0] retire_mask, hold_mask;
    logic [CW-1:0] commit_cnt, inst_cnt;
    logic [T-1:0] done_vld, store_commit, trap_wait;
    logic [T*SW-1:0] done_seq;
    logic serial_req, uload_req, trap_req, unk_err;
    logic [0:0] req_tid;
    logic [SW-1:0] req_seq;
    logic [T*PW-1:0] pc_out, npc_out;
    logic [T*UW-1:0] upc_out;

    cmt_retire_ctrl uut (
        .clk(clk), .rst_n(rst_n), .hd_valid(hd_valid), .hd_ready(hd_ready),
        .hd_squashed(hd_squashed), .hd_executed(hd_executed), .hd_fault(hd_fault),
        .hd_serial(hd_serial), .hd_load(hd_load), .hd_store(hd_store), .hd_nop(hd_nop),
        .hd_seq(hd_seq), .wb_pending(wb_pending), .trap_done(trap_done),
        .retire_mask(retire_mask), .hold_mask(hold_mask), .commit_cnt(commit_cnt),
        .inst_cnt(inst_cnt), .done_vld(done_vld), .done_seq(done_seq),
        .store_commit(store_commit), .serial_req(serial_req), .uload_req(uload_req),
        .trap_req(trap_req), .unk_err(unk_err), .req_tid(req_tid), .req_seq(req_seq),
        .trap_wait(trap_wait), .pc_out(pc_out), .npc_out(npc_out), .upc_out(upc_out)
    );

    int checks = 0;
    int errors = 0;

    // reference state
    bit          m_wait [T];
    int          m_rr;
    logic [PW-1:0] m_pc [T], m_npc [T], m_nnpc [T];
    logic [UW-1:0] m_upc [T], m_nupc [T];

    // reference predictions
    logic [NE-1:0] x_ret, x_hold;
    int            x_cc, x_ic;
    logic [T-1:0]  x_dv, x_sc;
    logic [T*SW-1:0] x_ds;
    bit            x_ns, x_ul, x_tr, x_er;
    int            x_tid;
    logic [SW-1:0] x_seq;
    int            x_adv [T];

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic clr();
        hd_valid = '0; hd_ready = '0; hd_squashed = '0; hd_executed = '0;
        hd_fault = '0; hd_serial = '0; hd_load = '0; hd_store = '0; hd_nop = '0;
        hd_seq = '0; wb_pending = '0; trap_done = '0;
    endtask

    // kind: 0 commit, 1 squashed, 2 serial unexecuted, 3 load unexecuted,
    //       4 fault, 5 unknown unexecuted, 6 not ready, 7 store commit, 8 nop commit
    task automatic put(input int t, input int k, input int kind, input int seq);
        int i;
        i = t*W + k;
        hd_valid[i] = 1'b1; hd_ready[i] = (kind != 6); hd_executed[i] = 1'b1;
        hd_squashed[i] = (kind == 1); hd_fault[i] = (kind == 4);
        hd_serial[i] = (kind == 2); hd_load[i] = (kind == 3);
        hd_store[i] = (kind == 7); hd_nop[i] = (kind == 8);
        if (kind == 2 || kind == 3 || kind == 5) hd_executed[i] = 1'b0;
        hd_seq[i*SW +: SW] = SW'(seq);
    endtask

    task automatic randomize_in();
        for (int i = 0; i < NE; i++) begin
            hd_valid[i]    = ($urandom_range(0, 9) < 8);
            hd_ready[i]    = ($urandom_range(0, 9) < 9);
            hd_squashed[i] = ($urandom_range(0, 9) < 2);
            hd_executed[i] = ($urandom_range(0, 9) < 8);
            hd_fault[i]    = ($urandom_range(0, 19) == 0);
            hd_serial[i]   = ($urandom_range(0, 9) == 0);
            hd_load[i]     = ($urandom_range(0, 9) < 2);
            hd_store[i]    = ($urandom_range(0, 9) < 3);
            hd_nop[i]      = ($urandom_range(0, 9) == 0);
            hd_seq[i*SW +: SW] = SW'($urandom);
        end
        for (int t = 0; t < T; t++) begin
            wb_pending[t] = ($urandom_range(0, 9) < 3);
            trap_done[t]  = ($urandom_range(0, 9) < 3);
        end
    endtask

    // behavioural walk over the windows
    task automatic predict();
        int pos [T];
        int t, i;
        bit go;
        x_ret = '0; x_hold = '0; x_cc = 0; x_ic = 0; x_dv = '0; x_sc = '0; x_ds = '0;
        x_ns = 0; x_ul = 0; x_tr = 0; x_er = 0; x_tid = 0; x_seq = '0;
        for (int k = 0; k < T; k++) begin pos[k] = 0; x_adv[k] = 0; end
        go = 1;
        while (go) begin
            if (x_cc == W) break;
            t = -1;
            for (int k = 0; k < T; k++) begin
                int c;
                c = (m_rr + k) % T;
                if (t == -1 && !m_wait[c] && pos[c] < W && hd_valid[c*W + pos[c]]) t = c;
            end
            if (t == -1) break;
            i = t*W + pos[t];
            if (!hd_ready[i]) break;
            if (hd_squashed[i]) begin
                x_ret[i] = 1'b1; pos[t]++;
                continue;
            end
            if (!hd_executed[i]) begin
                if (hd_serial[i] || hd_load[i]) begin
                    if (x_cc == 0 && !wb_pending[t]) begin
                        x_hold[i] = 1'b1; x_tid = t; x_seq = hd_seq[i*SW +: SW];
                        if (hd_serial[i]) x_ns = 1; else x_ul = 1;
                    end
                end else x_er = 1;
                break;
            end
            if (hd_fault[i]) begin
                if (x_cc == 0 && !wb_pending[t]) begin
                    x_tr = 1; x_tid = t; x_seq = hd_seq[i*SW +: SW];
                end
                break;
            end
            x_ret[i] = 1'b1; pos[t]++; x_cc++; x_adv[t]++;
            x_dv[t] = 1'b1; x_ds[t*SW +: SW] = hd_seq[i*SW +: SW];
            if (hd_store[i]) x_sc[t] = 1'b1;
            if (!hd_nop[i]) x_ic++;
        end
    endtask

    task automatic compare_all();
        chk("R1 commit_cnt", 64'(commit_cnt), 64'(x_cc));
        chk("R3 retire_mask", 64'(retire_mask), 64'(x_ret));
        chk("R4 hold_mask", 64'(hold_mask), 64'(x_hold));
        chk("R4 serial_req", 64'(serial_req), 64'(x_ns));
        chk("R5 uload_req", 64'(uload_req), 64'(x_ul));
        chk("R6 trap_req", 64'(trap_req), 64'(x_tr));
        chk("R4 req_tid", 64'(req_tid), 64'(x_tid));
        chk("R4 req_seq", 64'(req_seq), 64'(x_seq));
        chk("R8 store_commit", 64'(store_commit), 64'(x_sc));
        chk("R9 inst_cnt", 64'(inst_cnt), 64'(x_ic));
        chk("R10 unk_err", 64'(unk_err), 64'(x_er));
        chk("R11 done_vld", 64'(done_vld), 64'(x_dv));
        chk("R11 done_seq", 64'(done_seq), 64'(x_ds));
        for (int t = 0; t < T; t++) begin
            chk("R6 trap_wait", 64'(trap_wait[t]), 64'(m_wait[t]));
            chk("R7 pc", 64'(pc_out[t*PW +: PW]), 64'(m_pc[t]));
            chk("R7 npc", 64'(npc_out[t*PW +: PW]), 64'(m_npc[t]));
            chk("R7 upc", 64'(upc_out[t*UW +: UW]), 64'(m_upc[t]));
        end
    endtask

    task automatic advance_model();
        for (int t = 0; t < T; t++) begin
            for (int k = 0; k < x_adv[t]; k++) begin
                m_pc[t] = m_npc[t]; m_npc[t] = m_nnpc[t]; m_nnpc[t] = m_nnpc[t] + 4;
                m_upc[t] = m_nupc[t]; m_nupc[t] = m_upc[t] + 1;
            end
            if (m_wait[t]) begin
                if (trap_done[t]) m_wait[t] = 0;
            end else if (x_tr && x_tid == t) m_wait[t] = 1;
        end
        m_rr = (m_rr + 1) % T;
    endtask

    // one clock: inputs already driven at the falling edge
    task automatic step();
        #1;
        predict();
        compare_all();
        advance_model();
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        clr();
        m_rr = 0;
        for (int t = 0; t < T; t++) begin
            m_wait[t] = 0; m_pc[t] = RPC; m_npc[t] = RPC + 4; m_nnpc[t] = RPC + 8;
            m_upc[t] = 0; m_nupc[t] = 1;
        end
        repeat (3) @(negedge clk);
        // R12: reset state
        #1;
        chk("R12 commit_cnt", 64'(commit_cnt), 64'd0);
        chk("R12 retire_mask", 64'(retire_mask), 64'd0);
        chk("R12 trap_wait", 64'(trap_wait), 64'd0);
        for (int t = 0; t < T; t++) begin
            chk("R12 pc", 64'(pc_out[t*PW +: PW]), 64'(RPC));
            chk("R12 npc", 64'(npc_out[t*PW +: PW]), 64'(RPC + 4));
            chk("R12 upc", 64'(upc_out[t*UW +: UW]), 64'd0);
        end

        // R1/R3: squashed entries on thread 0 plus four commits on thread 1
        @(negedge clk); rst_n = 1'b1; clr();
        for (int k = 0; k < W; k++) put(0, k, 1, 10 + k);
        put(1, 0, 0, 20); put(1, 1, 7, 21); put(1, 2, 8, 22); put(1, 3, 0, 23);
        step();
        // R1: width reached with thread 1 first in order
        @(negedge clk); clr();
        for (int k = 0; k < W; k++) put(0, k, 0, 30 + k);
        for (int k = 0; k < W; k++) put(1, k, 0, 40 + k);
        step();
        // R4: commit then serialised head -> held
        @(negedge clk); clr();
        put(0, 0, 7, 50); put(0, 1, 2, 51); put(1, 0, 7, 52); put(1, 1, 2, 53);
        step();
        // R4: serialised head first, no writeback pending
        @(negedge clk); clr();
        put(0, 0, 2, 60); put(1, 0, 2, 61);
        step();
        // R4: serialised head first, writeback pending
        @(negedge clk); clr();
        put(0, 0, 2, 62); put(1, 0, 2, 63); wb_pending = '1;
        step();
        // R5: uncached load
        @(negedge clk); clr();
        put(0, 0, 3, 70); put(1, 0, 3, 71);
        step();
        // R6: fault waits for writeback, then traps
        @(negedge clk); clr();
        put(0, 0, 4, 80); put(1, 0, 4, 81); wb_pending = '1;
        step();
        @(negedge clk); clr();
        put(0, 0, 4, 82); put(1, 0, 4, 83);
        step();
        // R6: the trapped thread stays quiet
        for (int r = 0; r < 3; r++) begin
            @(negedge clk); clr();
            for (int k = 0; k < W; k++) begin put(0, k, 0, 90 + k); put(1, k, 0, 95 + k); end
            step();
        end
        @(negedge clk); clr(); trap_done = '1;
        step();
        // R10: unexecuted head of unknown kind
        @(negedge clk); clr();
        put(0, 0, 5, 100); put(1, 0, 5, 101);
        step();
        // R2: not-ready head stops the walk
        @(negedge clk); clr();
        put(0, 0, 6, 110); put(1, 0, 6, 111); put(0, 1, 0, 112);
        step();

        // random mixtures
        for (int n = 0; n < 4000; n++) begin
            @(negedge clk);
            randomize_in();
            step();
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule